// File: doc/BRIEF.md
# Clock Frequency Monitor

This block decides whether the system clock runs fast enough. It counts system clock cycles between pulses of a slower, trusted reference tick. When fewer cycles than a minimum fit into one reference period, the clock is judged too slow. While the clock is too slow the block drives an active-low error pin, and it shows the same condition as an active-high status bit.

The monitor is armed by reset: its enable bit comes out of reset set. While the reset-inhibit input is high the error stays off, but the frequency measurement keeps running. So if the clock is still slow when the inhibit ends, the error appears on the next cycle. Once the clock is fast enough again, the error does not drop at once. It waits for the next 16-tick boundary of a free-running count of T0 ticks, then counts 16 more T0 ticks. This gives a settling time of 17 to 32 T0 ticks. Software can clear or set the enable bit through a write strobe.

Top module: `clk_freq_mon`

## Requirements
- R1: After reset the enable bit reads 1, `error_n_o` is 1 and `err_o` is 0.
- R2: While `inhibit_i` is high, `error_n_o` is 1 from the next clock on. This holds even if an error was active.
- R3: If the clock was judged slow when `inhibit_i` falls, `error_n_o` goes low on the first clock after the fall.
- R4: If the reference periods measured during the inhibit show at least `MIN_CYC` cycles, no error follows the release.
- R5: A reference tick that arrives fewer than `MIN_CYC` system clocks after the previous one marks the clock slow on that edge. The error is asserted on the following edge.
- R6: `err_o` is always the inverse of `error_n_o`.
- R7: After a reference period of at least `MIN_CYC` cycles ends a slow phase, the error clears on the T0 tick that is 17 to 32 T0 ticks later. That tick is the 16th T0 tick after the first tick at which the free-running 4-bit T0 count wraps.
- R8: A slow reference period during the settling interval keeps the error asserted. A later recovery then needs a full new 17 to 32 T0-tick interval.
- R9: Writing 0 to the enable bit (`en_wr_i`=1, `en_wdata_i`=0) forces `error_n_o` high on the second edge after the write. It also discards any settling progress, and `en_o` reads back 0.
- R10: Writing 1 to the enable bit while the clock is slow brings the error back within two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock under test |
| rst_n | input | 1 | Asynchronous active-low reset |
| inhibit_i | input | 1 | High while the chip is held in reset; suppresses the error |
| t0_tick_i | input | 1 | One-cycle T0 time-base pulse |
| ref_tick_i | input | 1 | One-cycle pulse from the trusted reference time base |
| en_wr_i | input | 1 | Write strobe for the enable bit |
| en_wdata_i | input | 1 | Value written to the enable bit |
| en_o | output | 1 | Current enable bit |
| err_o | output | 1 | Status: clock currently flagged as too slow |
| error_n_o | output | 1 | Active-low error pin |

## Verification
The hardest case to reach is a relapse inside the settling window. The clock must recover, part of the 17 to 32 tick interval must pass, and then one short reference period must occur before the window closes. The bench gets there by choosing the spacing of the reference ticks. It waits for the first long period that ends a slow phase, lets ten T0 ticks go by, and then switches to short spacing until a short interval is actually seen. After that it restores long spacing and measures the complete clearing interval again in T0 ticks.

// File: rtl/clk_freq_mon.sv
module clk_freq_mon #(
  parameter int MIN_CYC   = 20,
  parameter int SETTLE_T0 = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inhibit_i,
  input  logic t0_tick_i,
  input  logic ref_tick_i,
  input  logic en_wr_i,
  input  logic en_wdata_i,
  output logic en_o,
  output logic err_o,
  output logic error_n_o
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam int PW = $clog2(SETTLE_T0);
  localparam logic [CW-1:0] PER_MAX = CW'(MIN_CYC - 1);
  localparam logic [PW-1:0] SC_LAST = PW'(SETTLE_T0 - 1);

  logic [CW-1:0] per_cnt;
  logic [PW-1:0] t0_ph, sc_q;
  logic slow_q, en_q, err_q, armed_q;
  logic hold_off, boundary;

  assign hold_off  = inhibit_i | ~en_q;
  assign boundary  = t0_tick_i & (t0_ph == '1);
  assign en_o      = en_q;
  assign err_o     = err_q;
  assign error_n_o = ~err_q;

  // Cycles since last reference tick, saturating at the threshold
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt <= '0;
      slow_q  <= 1'b1;
    end else if (ref_tick_i) begin
      per_cnt <= '0;
      slow_q  <= (per_cnt < PER_MAX);
    end else if (per_cnt != PER_MAX) begin
      per_cnt <= per_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         t0_ph <= '0;
    else if (t0_tick_i) t0_ph <= t0_ph + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= 1'b1;
    else if (en_wr_i) en_q <= en_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      armed_q <= 1'b0;
      sc_q    <= '0;
    end else if (hold_off) begin
      err_q   <= 1'b0;
      armed_q <= 1'b0;
      sc_q    <= '0;
    end else if (slow_q) begin
      err_q   <= 1'b1;
      armed_q <= 1'b0;
      sc_q    <= '0;
    end else if (err_q && t0_tick_i) begin
      if (!armed_q) begin
        armed_q <= boundary;
        sc_q    <= '0;
      end else if (sc_q == SC_LAST) begin
        err_q   <= 1'b0;
        armed_q <= 1'b0;
        sc_q    <= '0;
      end else begin
        sc_q <= sc_q + 1'b1;
      end
    end
  end

  a_r2_inhibit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_i |=> error_n_o);

  a_r9_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !err_o);

  a_r5_slow_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_q && en_q && !inhibit_i) |=> err_o);

  a_r7_clear_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(err_q) && $past(en_q) && !$past(inhibit_i)) |-> ($past(armed_q) && $past(t0_tick_i)));

  a_r8_no_clear_when_slow: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(slow_q) && $past(en_q) && !$past(inhibit_i)) |-> err_q);

  a_r6_pins_agree: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $fell(error_n_o));
endmodule

// File: tb/clk_freq_mon_tb_top.sv
`timescale 1ns/1ps
module clk_freq_mon_tb_top;
  localparam int MIN = 20;
  localparam int GOOD = 32;
  localparam int SLOW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0, inhibit = 1'b1, t0_tick = 1'b0, ref_tick = 1'b0;
  logic en_wr = 1'b0, en_wdata = 1'b0;
  logic en_o, err_o, error_n_o;
  int n_chk = 0, n_fail = 0, cyc = 0;
  int ref_period = SLOW, ref_since = 0, ref_gap = 0, t0_div = 0;

  always #2.5 clk = ~clk;

  clk_freq_mon #(.MIN_CYC(MIN), .SETTLE_T0(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .inhibit_i(inhibit), .t0_tick_i(t0_tick),
    .ref_tick_i(ref_tick), .en_wr_i(en_wr), .en_wdata_i(en_wdata),
    .en_o(en_o), .err_o(err_o), .error_n_o(error_n_o));

  always @(negedge clk) begin
    t0_div = (t0_div + 1) % 4;
    t0_tick = (t0_div == 0);
    if (ref_since >= ref_period - 1) begin
      ref_tick = 1'b1; ref_gap = ref_since + 1; ref_since = 0;
    end else begin
      ref_tick = 1'b0; ref_since++;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_pins(input string req, input int exp_err);
    chk(req, err_o, exp_err);
    chk({req, " R6"}, error_n_o, !exp_err);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wait_ref(input bit good);
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #1;
      if (ref_tick && (good ? (ref_gap >= MIN) : (ref_gap < MIN))) return;
    end
  endtask

  task automatic write_en(input bit v);
    en_wr = 1'b1; en_wdata = v;
    step(1);
    en_wr = 1'b0;
  endtask

  task automatic measure_clear(input string req);
    int ticks = 0;
    bit done = 0;
    wait_ref(1);
    for (int i = 0; i < 600 && !done; i++) begin
      @(posedge clk); #1;
      if (t0_tick) ticks++;
      if (!err_o) done = 1;
    end
    if (!done) ticks = 999;
    n_chk++;
    if (ticks < 17 || ticks > 32) begin
      n_fail++;
      $display("FAIL %s: actual %0d T0 ticks, expected 17..32", req, ticks);
    end
    chk({req, " pin"}, error_n_o, 1);
  endtask

  task automatic t_reset();
    step(3);
    chk("R1 en", en_o, 1);
    chk_pins("R1", 0);
    rst_n = 1'b1;
  endtask

  task automatic t_inhibit_slow();
    ref_period = SLOW;
    for (int i = 0; i < 6; i++) begin step(10); chk("R2 pin", error_n_o, 1); end
    inhibit = 1'b0;
    step(1);
    chk_pins("R3", 1);
  endtask

  task automatic t_slow_detect();
    ref_period = GOOD;
    measure_clear("R7 first");
    step(20);
    chk_pins("R5 idle", 0);
    ref_period = SLOW;
    wait_ref(0);
    chk("R5 same edge", err_o, 0);
    step(1);
    chk_pins("R5 raised", 1);
  endtask

  task automatic t_relapse();
    bit dropped = 0;
    ref_period = GOOD;
    wait_ref(1);
    for (int n = 0; n < 10; ) begin step(1); if (t0_tick) n++; end
    chk("R8 mid settle", err_o, 1);
    ref_period = SLOW;
    wait_ref(0);
    for (int i = 0; i < 30; i++) begin step(1); if (!err_o) dropped = 1; end
    chk("R8 held", dropped, 0);
    ref_period = GOOD;
    measure_clear("R8 full restart");
  endtask

  task automatic t_enable();
    ref_period = SLOW;
    wait_ref(0);
    step(2);
    chk_pins("R9 pre", 1);
    write_en(1'b0);
    chk("R9 en_o", en_o, 0);
    step(1);
    chk_pins("R9 forced", 0);
    step(40);
    chk_pins("R9 stays", 0);
    write_en(1'b1);
    step(1);
    chk_pins("R10 rearm", 1);
    ref_period = GOOD;
    wait_ref(1);
    step(12);
    write_en(1'b0);
    step(2);
    write_en(1'b1);
    step(40);
    chk_pins("R9 settle dropped", 0);
  endtask

  task automatic t_inhibit_mid();
    ref_period = SLOW;
    wait_ref(0);
    step(2);
    chk_pins("R2 pre", 1);
    inhibit = 1'b1;
    step(1);
    chk_pins("R2 mid error", 0);
    step(30);
    chk("R2 held", error_n_o, 1);
  endtask

  task automatic t_reset_good();
    rst_n = 1'b0; inhibit = 1'b1;
    ref_period = GOOD;
    step(3);
    chk("R1 again en", en_o, 1);
    rst_n = 1'b1;
    step(4 * GOOD);
    inhibit = 1'b0;
    step(1);
    chk_pins("R4 release", 0);
    step(60);
    chk_pins("R4 later", 0);
  endtask

  initial begin
    t_reset();
    t_inhibit_slow();
    t_slow_detect();
    t_relapse();
    t_enable();
    t_inhibit_mid();
    t_reset_good();
    summary();
  end
endmodule